// File: doc/BRIEF.md
# DMA Control Register and Service Scheduler

This block holds the controller-wide state of a four-channel DMA controller: a command byte, a status byte that carries per-channel completion flags in its low nibble and per-channel service requests in its high nibble, a four-bit channel mask, one mode byte per channel and the byte-pointer flip-flop. Software reaches all of it through an 8-bit write port with a 3-bit register offset. Devices raise and drop service requests through hold and release lines. The transfer engine reports completions on a set of completion-flag lines.

The scheduler looks at the registered request and mask bits. It names one channel that may be serviced now: the lowest-numbered channel whose request is set and whose mask is clear. For that channel it also forms the full transfer address and the transfer length, using per-channel page, current-address and base-count buses supplied by the channel register port.

Top module: `dmac_ctl_sched`

## Requirements
- R1: After reset the mask is all ones, status, command and every mode byte are zero, the byte pointer is 0, cmd_err is low and no grant is given.
- R2: A write to offset 0 with data zero stores zero as the command. A write to offset 0 with any nonzero data leaves the command unchanged and raises cmd_err for exactly the next cycle.
- R3: A write to offset 1 takes the channel from data bits 1:0 and copies data bit 2 into status bit (channel+4). It also clears status bit (channel). A completion line that is high in the same cycle still sets its status bit (channel).
- R4: A write to offset 2 takes the channel from data bits 1:0. It sets that channel's mask bit when data bit 2 is 1 and clears it when data bit 2 is 0.
- R5: A write to offset 3 stores the whole data byte as the mode byte of the channel named by data bits 1:0.
- R6: A write to offset 5 sets the mask to all ones and clears status, command and the byte pointer. It overrides every other update in the same cycle.
- R7: A write to offset 6 clears all mask bits. A write to offset 7 loads the mask from data bits 3:0.
- R8: A pulse on ptr_flip toggles the byte pointer. A write to offset 4 or 5 clears it, and the clear wins over a flip in the same cycle.
- R9: hold_req bit n sets status bit (n+4) and release_req bit n clears it. Release wins over hold, and both win over a software request write in the same cycle.
- R10: grant_vld is high in the same cycle as the registered state whenever some channel has its request bit set and its mask bit clear. grant_ch is then the lowest such channel.
- R11: While a grant is given, xfer_addr equals the granted channel's 8-bit page placed above its 16-bit current address. With no grant it is zero.
- R12: While a grant is given, xfer_len equals the granted channel's base count plus one, doubled when word_mode is high. With no grant it is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Control write strobe |
| wr_off | input | 3 | Control register offset |
| wr_data | input | 8 | Control write data |
| hold_req | input | 4 | Per-channel external request set |
| release_req | input | 4 | Per-channel external request clear |
| tc_in | input | 4 | Per-channel completion flag set |
| ptr_flip | input | 1 | Byte-pointer toggle from the channel port |
| word_mode | input | 1 | Double the transfer length |
| page_all | input | 32 | Page byte per channel, channel n at bits 8n+7:8n |
| addr_all | input | 64 | Current address per channel, 16 bits each |
| cnt_all | input | 64 | Base count per channel, 16 bits each |
| cmd_q | output | 8 | Command register |
| status_q | output | 8 | Requests in bits 7:4, completion flags in bits 3:0 |
| mask_q | output | 4 | Channel mask |
| mode_all | output | 32 | Mode byte per channel, channel n at bits 8n+7:8n |
| ptr_q | output | 1 | Byte-pointer flip-flop |
| cmd_err | output | 1 | Rejected command write, one-cycle pulse |
| grant_vld | output | 1 | A channel is eligible for service |
| grant_ch | output | 2 | Granted channel |
| xfer_addr | output | 24 | Transfer address of the granted channel |
| xfer_len | output | 18 | Transfer length of the granted channel |

## Verification
Every register is visible at the ports. A wrong mask, request or mode bit therefore shows up on the cycle after the write that set it, or the cycle after the hold, release or completion line that set it. Because grant, address and length are formed combinationally from that registered state, a corrupted request or mask bit changes grant_ch, xfer_addr or xfer_len in the same cycle the bad state appears. The bench places a behavioural model of each write and line update beside the design and compares all outputs every cycle. Same-cycle collisions (release against hold, a completion against a request write, master clear against everything) occur under random stimulus as well as in directed steps.

// File: rtl/dmac_ctl_pkg.sv
package dmac_ctl_pkg;

    typedef enum logic [2:0] {
        OFF_CMD        = 3'd0,
        OFF_REQ        = 3'd1,
        OFF_SMASK      = 3'd2,
        OFF_MODE       = 3'd3,
        OFF_PTRCLR     = 3'd4,
        OFF_MCLR       = 3'd5,
        OFF_UNMASK_ALL = 3'd6,
        OFF_LOAD_MASK  = 3'd7
    } ctl_off_e;

endpackage

// File: rtl/dmac_ctl_regs.sv
module dmac_ctl_regs
    import dmac_ctl_pkg::*;
#(
    parameter int NCH = 4,
    parameter int DW  = 8,
    localparam int CW = $clog2(NCH)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [2:0]            wr_off,
    input  logic [DW-1:0]         wr_data,
    input  logic [NCH-1:0]        hold_req,
    input  logic [NCH-1:0]        release_req,
    input  logic [NCH-1:0]        tc_in,
    input  logic                  ptr_flip,
    output logic [DW-1:0]         cmd_q,
    output logic [NCH-1:0]        req_q,
    output logic [NCH-1:0]        term_q,
    output logic [NCH-1:0]        mask_q,
    output logic [NCH*DW-1:0]     mode_q,
    output logic                  ptr_q,
    output logic                  cmd_err
);

    typedef struct packed {
        logic [DW-1:0]            cmd;
        logic [NCH-1:0]           req;
        logic [NCH-1:0]           term;
        logic [NCH-1:0]           mask;
        logic [NCH-1:0][DW-1:0]   mode;
        logic                     ptr;
        logic                     err;
    } ctl_state_s;

    ctl_state_s st_d, st_q;
    ctl_off_e   off;
    logic [CW-1:0] sel;
    logic       val_bit;
    logic       is_mclr;

    assign off     = ctl_off_e'(wr_off);
    assign sel     = wr_data[CW-1:0];
    assign val_bit = wr_data[CW];
    assign is_mclr = wr_en && (off == OFF_MCLR);

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;
        if (wr_en) begin
            case (off)
                OFF_CMD: begin
                    if (wr_data != '0) st_d.err = 1'b1;
                    else               st_d.cmd = '0;
                end
                OFF_REQ: begin
                    st_d.req[sel]  = val_bit;
                    st_d.term[sel] = 1'b0;
                end
                OFF_SMASK:      st_d.mask[sel] = val_bit;
                OFF_MODE:       st_d.mode[sel] = wr_data;
                OFF_UNMASK_ALL: st_d.mask = '0;
                OFF_LOAD_MASK:  st_d.mask = wr_data[NCH-1:0];
                default: ;
            endcase
        end
        // byte pointer: clear beats toggle
        if (wr_en && (off == OFF_PTRCLR || off == OFF_MCLR)) st_d.ptr = 1'b0;
        else                                                 st_d.ptr = st_q.ptr ^ ptr_flip;
        // line updates follow software, release last
        st_d.term = st_d.term | tc_in;
        st_d.req  = (st_d.req | hold_req) & ~release_req;
        if (is_mclr) begin
            st_d.cmd  = '0;
            st_d.req  = '0;
            st_d.term = '0;
            st_d.mask = '1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.mask <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmd_q   = st_q.cmd;
    assign req_q   = st_q.req;
    assign term_q  = st_q.term;
    assign mask_q  = st_q.mask;
    assign mode_q  = st_q.mode;
    assign ptr_q   = st_q.ptr;
    assign cmd_err = st_q.err;

    assert_cmd_reject_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && off == OFF_CMD && wr_data != '0) |=> (cmd_err && cmd_q == $past(cmd_q)));

    assert_single_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && off == OFF_SMASK) |=> (mask_q[$past(sel)] == $past(val_bit)));

    assert_master_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        is_mclr |=> (mask_q == '1 && req_q == '0 && term_q == '0 && cmd_q == '0 && !ptr_q));

    assert_release_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (release_req != '0) |=> ((req_q & $past(release_req)) == '0));

endmodule

// File: rtl/dmac_pick.sv
module dmac_pick #(
    parameter int NCH = 4,
    localparam int CW = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] req,
    input  logic [NCH-1:0] mask,
    output logic           grant_vld,
    output logic [CW-1:0]  grant_ch
);

    logic [NCH-1:0] elig;

    assign elig = req & ~mask;

    // descending scan so the lowest eligible channel is the last to write
    always_comb begin
        grant_vld = 1'b0;
        grant_ch  = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (elig[i]) begin
                grant_vld = 1'b1;
                grant_ch  = CW'(i);
            end
        end
    end

    assert_grant_eligible_R10: assert property (@(posedge clk) disable iff (!rst_n)
        grant_vld |-> (req[grant_ch] && !mask[grant_ch]));

    assert_grant_lowest_R10: assert property (@(posedge clk) disable iff (!rst_n)
        grant_vld |-> ((req & ~mask & ((NCH'(1) << grant_ch) - NCH'(1))) == '0));

    assert_grant_present_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((req & ~mask) != '0) |-> grant_vld);

endmodule

// File: rtl/dmac_xfer_calc.sv
module dmac_xfer_calc #(
    parameter int NCH  = 4,
    parameter int PW   = 8,
    parameter int AW   = 16,
    parameter int CNTW = 16,
    localparam int CW  = $clog2(NCH),
    localparam int LW  = CNTW + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              grant_vld,
    input  logic [CW-1:0]     grant_ch,
    input  logic              word_mode,
    input  logic [NCH*PW-1:0] page_all,
    input  logic [NCH*AW-1:0] addr_all,
    input  logic [NCH*CNTW-1:0] cnt_all,
    output logic [PW+AW-1:0]  xfer_addr,
    output logic [LW-1:0]     xfer_len
);

    logic [NCH-1:0][PW+AW-1:0] full_addr;
    logic [NCH-1:0][LW-1:0]    span;

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        logic [LW-1:0] cnt_ext;
        assign cnt_ext      = {2'b00, cnt_all[c*CNTW +: CNTW]} + LW'(1);
        assign full_addr[c] = {page_all[c*PW +: PW], addr_all[c*AW +: AW]};
        assign span[c]      = word_mode ? (cnt_ext << 1) : cnt_ext;
    end

    always_comb begin
        xfer_addr = '0;
        xfer_len  = '0;
        if (grant_vld) begin
            xfer_addr = full_addr[grant_ch];
            xfer_len  = span[grant_ch];
        end
    end

    assert_idle_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !grant_vld |-> (xfer_len == '0 && xfer_addr == '0));

    assert_len_nonzero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        grant_vld |-> (xfer_len != '0));

endmodule

// File: rtl/dmac_ctl_sched.sv
module dmac_ctl_sched
    import dmac_ctl_pkg::*;
#(
    parameter int NCH  = 4,
    parameter int DW   = 8,
    parameter int PW   = 8,
    parameter int AW   = 16,
    parameter int CNTW = 16,
    localparam int CW  = $clog2(NCH),
    localparam int LW  = CNTW + 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [2:0]           wr_off,
    input  logic [DW-1:0]        wr_data,
    input  logic [NCH-1:0]       hold_req,
    input  logic [NCH-1:0]       release_req,
    input  logic [NCH-1:0]       tc_in,
    input  logic                 ptr_flip,
    input  logic                 word_mode,
    input  logic [NCH*PW-1:0]    page_all,
    input  logic [NCH*AW-1:0]    addr_all,
    input  logic [NCH*CNTW-1:0]  cnt_all,
    output logic [DW-1:0]        cmd_q,
    output logic [2*NCH-1:0]     status_q,
    output logic [NCH-1:0]       mask_q,
    output logic [NCH*DW-1:0]    mode_all,
    output logic                 ptr_q,
    output logic                 cmd_err,
    output logic                 grant_vld,
    output logic [CW-1:0]        grant_ch,
    output logic [PW+AW-1:0]     xfer_addr,
    output logic [LW-1:0]        xfer_len
);

    logic [NCH-1:0] req_q;
    logic [NCH-1:0] term_q;

    dmac_ctl_regs #(.NCH(NCH), .DW(DW)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_off      (wr_off),
        .wr_data     (wr_data),
        .hold_req    (hold_req),
        .release_req (release_req),
        .tc_in       (tc_in),
        .ptr_flip    (ptr_flip),
        .cmd_q       (cmd_q),
        .req_q       (req_q),
        .term_q      (term_q),
        .mask_q      (mask_q),
        .mode_q      (mode_all),
        .ptr_q       (ptr_q),
        .cmd_err     (cmd_err)
    );

    assign status_q = {req_q, term_q};

    dmac_pick #(.NCH(NCH)) u_pick (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req_q),
        .mask      (mask_q),
        .grant_vld (grant_vld),
        .grant_ch  (grant_ch)
    );

    dmac_xfer_calc #(.NCH(NCH), .PW(PW), .AW(AW), .CNTW(CNTW)) u_calc (
        .clk       (clk),
        .rst_n     (rst_n),
        .grant_vld (grant_vld),
        .grant_ch  (grant_ch),
        .word_mode (word_mode),
        .page_all  (page_all),
        .addr_all  (addr_all),
        .cnt_all   (cnt_all),
        .xfer_addr (xfer_addr),
        .xfer_len  (xfer_len)
    );

endmodule

// File: tb/sim_dmac_ctl_sched.sv
module sim_dmac_ctl_sched;
    import dmac_ctl_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_off = '0;
    logic [7:0]  wr_data = '0;
    logic [3:0]  hold_req = '0, release_req = '0, tc_in = '0;
    logic        ptr_flip = 1'b0, word_mode = 1'b0;
    logic [31:0] page_all = '0;
    logic [63:0] addr_all = '0, cnt_all = '0;
    logic [7:0]  cmd_q, status_q;
    logic [3:0]  mask_q;
    logic [31:0] mode_all;
    logic        ptr_q, cmd_err, grant_vld;
    logic [1:0]  grant_ch;
    logic [23:0] xfer_addr;
    logic [17:0] xfer_len;

    int checks = 0;
    int errors = 0;

    // reference state
    logic [7:0] m_cmd;
    logic [3:0] m_req, m_term, m_mask;
    logic [7:0] m_mode [4];
    logic       m_ptr, m_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    dmac_ctl_sched u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_off(wr_off), .wr_data(wr_data),
        .hold_req(hold_req), .release_req(release_req), .tc_in(tc_in), .ptr_flip(ptr_flip),
        .word_mode(word_mode), .page_all(page_all), .addr_all(addr_all), .cnt_all(cnt_all),
        .cmd_q(cmd_q), .status_q(status_q), .mask_q(mask_q), .mode_all(mode_all),
        .ptr_q(ptr_q), .cmd_err(cmd_err), .grant_vld(grant_vld), .grant_ch(grant_ch),
        .xfer_addr(xfer_addr), .xfer_len(xfer_len)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int exp_grant();
        for (int i = 0; i < 4; i++)
            if (m_req[i] && !m_mask[i]) return i;
        return -1;
    endfunction

    task automatic compare_all();
        int g;
        logic [31:0] e_addr, e_len;
        g = exp_grant();
        chk("R2 command", {24'h0, cmd_q}, {24'h0, m_cmd});
        chk("R2 cmd_err", {31'h0, cmd_err}, {31'h0, m_err});
        chk("R3/R9 status", {24'h0, status_q}, {24'h0, m_req, m_term});
        chk("R4/R6/R7 mask", {28'h0, mask_q}, {28'h0, m_mask});
        chk("R5 modes", mode_all, {m_mode[3], m_mode[2], m_mode[1], m_mode[0]});
        chk("R8 byte pointer", {31'h0, ptr_q}, {31'h0, m_ptr});
        chk("R10 grant_vld", {31'h0, grant_vld}, {31'h0, (g >= 0)});
        e_addr = 0;
        e_len  = 0;
        if (g >= 0) begin
            chk("R10 grant_ch", {30'h0, grant_ch}, g[31:0]);
            e_addr = {8'h0, page_all[g*8 +: 8], addr_all[g*16 +: 16]};
            e_len  = {16'h0, cnt_all[g*16 +: 16]} + 32'd1;
            if (word_mode) e_len = e_len * 2;
        end
        chk("R11 xfer_addr", {8'h0, xfer_addr}, e_addr);
        chk("R12 xfer_len", {14'h0, xfer_len}, e_len);
    endtask

    task automatic model_update();
        logic [1:0] s;
        s = wr_data[1:0];
        m_err = 1'b0;
        if (wr_en) begin
            case (wr_off)
                3'd0: if (wr_data != 0) m_err = 1'b1; else m_cmd = 8'h00;
                3'd1: begin m_req[s] = wr_data[2]; m_term[s] = 1'b0; end
                3'd2: m_mask[s] = wr_data[2];
                3'd3: m_mode[s] = wr_data;
                3'd6: m_mask = 4'h0;
                3'd7: m_mask = wr_data[3:0];
                default: ;
            endcase
        end
        if (wr_en && (wr_off == 3'd4 || wr_off == 3'd5)) m_ptr = 1'b0;
        else if (ptr_flip) m_ptr = ~m_ptr;
        m_term = m_term | tc_in;
        m_req  = (m_req | hold_req) & ~release_req;
        if (wr_en && wr_off == 3'd5) begin
            m_cmd = 8'h00; m_req = 4'h0; m_term = 4'h0; m_mask = 4'hF;
        end
    endtask

    task automatic step(input logic we, input logic [2:0] off, input logic [7:0] d,
                        input logic [3:0] h, input logic [3:0] r, input logic [3:0] t,
                        input logic fl);
        @(negedge clk);
        wr_en = we; wr_off = off; wr_data = d;
        hold_req = h; release_req = r; tc_in = t; ptr_flip = fl;
        #1 compare_all();
        @(posedge clk);
        model_update();
    endtask

    task automatic wr(input logic [2:0] off, input logic [7:0] d);
        step(1'b1, off, d, 4'h0, 4'h0, 4'h0, 1'b0);
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        m_cmd = 0; m_req = 0; m_term = 0; m_mask = 4'hF; m_ptr = 0; m_err = 0;
        for (int i = 0; i < 4; i++) m_mode[i] = 8'h00;
        page_all = 32'h44332211;
        addr_all = 64'hD004_C003_B002_A001;
        cnt_all  = 64'h0003_FFFF_0010_0000;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1 mask", {28'h0, mask_q}, 32'hF);
        chk("R1 status", {24'h0, status_q}, 32'h0);
        chk("R1 command", {24'h0, cmd_q}, 32'h0);
        chk("R1 modes", mode_all, 32'h0);
        chk("R1 ptr/err/grant", {29'h0, ptr_q, cmd_err, grant_vld}, 32'h0);
        rst_n = 1'b1;

        wr(3'd6, 8'h00);                  // R7 unmask all, no requests: no grant
        wr(3'd0, 8'h00);                  // R2 accepted
        wr(3'd0, 8'h05);                  // R2 rejected, err next cycle
        wr(3'd1, 8'h06);                  // R3 request ch2
        wr(3'd1, 8'h05);                  // R3 request ch1, R10 lower wins
        word_mode = 1'b1;
        wr(3'd2, 8'h05);                  // R4 mask ch1, grant back to ch2
        word_mode = 1'b0;
        step(1'b0, 3'd0, 8'h00, 4'h0, 4'h0, 4'h4, 1'b0);   // completion ch2
        step(1'b1, 3'd1, 8'h06, 4'h0, 4'h0, 4'h1, 1'b0);   // R3 clears term2, tc sets term0
        step(1'b1, 3'd1, 8'h07, 4'h8, 4'h8, 4'h0, 1'b0);   // R9 release beats hold and write
        step(1'b1, 3'd1, 8'h03, 4'h8, 4'h0, 4'h0, 1'b0);   // R9 hold beats clear write ch3
        wr(3'd2, 8'h01);                  // R4 unmask ch1
        wr(3'd3, 8'hA9);                  // R5 mode ch1
        wr(3'd3, 8'h56);                  // R5 mode ch2
        step(1'b0, 3'd0, 8'h00, 4'h0, 4'h0, 4'h0, 1'b1);   // R8 flip
        step(1'b1, 3'd4, 8'h00, 4'h0, 4'h0, 4'h0, 1'b1);   // R8 clear wins
        step(1'b0, 3'd0, 8'h00, 4'h0, 4'h0, 4'h0, 1'b1);
        wr(3'd7, 8'hF6);                  // R7 load mask 0110
        step(1'b1, 3'd5, 8'h00, 4'hF, 4'h0, 4'hF, 1'b1);   // R6 master clear overrides
        wr(3'd7, 8'h00);
        step(1'b0, 3'd0, 8'h00, 4'h0, 4'h0, 4'h0, 1'b0);

        for (int n = 0; n < 4000; n++) begin
            page_all  = $urandom;
            addr_all  = {$urandom, $urandom};
            cnt_all   = {$urandom, $urandom};
            word_mode = 1'($urandom);
            step(1'($urandom), 3'($urandom), ($urandom_range(0, 3) == 0) ? 8'h00 : 8'($urandom),
                 4'($urandom & $urandom), 4'($urandom & $urandom & $urandom),
                 4'($urandom & $urandom), 1'($urandom));
        end
        @(negedge clk);
        #1 compare_all();
        finish_run();
    end

endmodule